// File: doc/BRIEF.md
# Timer interrupt flag register unit

This unit keeps the event flags of an eight-channel capture/compare timer and one extra flag for counter overflow. A one-cycle event pulse from the timer sets a flag, and the flag stays set until software clears it. The eight channel flags share one byte register. The overflow flag is the top bit of a second byte register. Each flag is ANDed with its own enable input to form one interrupt request line per flag.

Software reaches the unit through a simple synchronous byte bus with an address, write data, write and read strobes, and combinational read data. Writing a one to a flag bit clears that flag. When the fast-clear input is high, ordinary traffic to the timer also clears flags as a side effect:

- For a channel in capture mode, a read of its two-byte register pair clears its flag.
- For a channel in compare mode, a write to its two-byte register pair clears its flag.
- Any read or write of the two-byte counter pair clears the overflow flag.

The channel and counter registers do not live in this unit. For those addresses it only observes the access.

Top module: `tmr_flag_unit`

## Requirements
- R1: While reset is asserted and just after it, every flag is 0. This means both flag registers read 0x00 and all interrupt outputs are low.
- R2: A pulse on `ch_evt[n]` sets channel flag n. From the next cycle it reads as bit n of the channel flag register at address 0x8E.
- R3: A pulse on `ovf_evt` sets the overflow flag. It reads as bit 7 of the register at 0x8F, and bits 6..0 of that register always read 0.
- R4: A write to 0x8E clears each channel flag whose write-data bit is 1. A write to 0x8F with bit 7 set clears the overflow flag. Written 0 bits leave flags unchanged. This path works whatever the value of `fast_clr`.
- R5: Reading 0x8E or 0x8F never changes any flag.
- R6: Channel n owns addresses 0x90+2n and 0x91+2n. With `fast_clr`=1 and `ch_is_cap[n]`=1 (capture), a read of either byte clears flag n, and a write to it does not.
- R7: With `fast_clr`=1 and `ch_is_cap[n]`=0 (compare), a write to either byte of channel n clears flag n, and a read does not.
- R8: With `fast_clr`=1, a read or a write of either counter byte clears the overflow flag. The counter bytes are at 0x84 and 0x85 by default.
- R9: With `fast_clr`=0, accesses to channel or counter addresses leave all flags unchanged.
- R10: When a set event and any clear of the same flag fall in the same cycle, the flag ends up set.
- R11: `ch_irq[n]` equals flag n AND `ch_ie[n]`, and `ovf_irq` equals the overflow flag AND `ovf_ie`. Both follow the enables in the same cycle.
- R12: Every address other than 0x8E and 0x8F reads 0x00, channel and counter addresses included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Bus address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Combinational read data for `addr` |
| ch_evt | input | 8 | Per-channel set pulses |
| ovf_evt | input | 1 | Counter overflow set pulse |
| ch_is_cap | input | 8 | Per-channel mode, 1 = capture, 0 = compare |
| fast_clr | input | 1 | Enables the side-effect clear paths |
| ch_ie | input | 8 | Per-channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ch_irq | output | 8 | Per-channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a clear that arrives in the same cycle as a set event on the same flag. The side-effect clears make it harder still, because each one depends on three things lining up in that cycle: the channel's mode bit, the strobe direction and the fast-clear input. Directed steps build each of these collisions on purpose, including one in which write-one-to-clear meets a new event. A long random phase then draws addresses mostly from the flag, channel and counter addresses, with sparse events, random modes and random fast-clear. A bench reference model predicts the read data and every interrupt line in each cycle.

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CH_FLAG_ADDR = 8'h8E,
  parameter logic [AW-1:0] OVF_FLAG_ADDR = 8'h8F,
  parameter logic [AW-1:0] CH_BASE_ADDR = 8'h90,
  parameter logic [AW-1:0] CNT_ADDR = 8'h84
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  input  logic [7:0]    ch_evt,
  input  logic          ovf_evt,
  input  logic [7:0]    ch_is_cap,
  input  logic          fast_clr,
  input  logic [7:0]    ch_ie,
  input  logic          ovf_ie,
  output logic [7:0]    ch_irq,
  output logic          ovf_irq
);
  localparam int NCH = 8;

  logic [NCH-1:0] ch_flag, ch_hit, ch_clr;
  logic ovf_flag, ovf_clr, cnt_hit, wr_chf, wr_ovf;

  assign wr_chf  = wr_en && (addr == CH_FLAG_ADDR);
  assign wr_ovf  = wr_en && (addr == OVF_FLAG_ADDR);
  assign cnt_hit = (addr[AW-1:1] == CNT_ADDR[AW-1:1]);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] PAIR = CH_BASE_ADDR + AW'(2 * n);
    assign ch_hit[n] = (addr[AW-1:1] == PAIR[AW-1:1]);
    assign ch_clr[n] = (wr_chf && wdata[n]) ||
                       (fast_clr && ch_hit[n] && (ch_is_cap[n] ? rd_en : wr_en));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ch_flag[n] <= 1'b0;
      else        ch_flag[n] <= ch_evt[n] | (ch_flag[n] & ~ch_clr[n]);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt[n] |=> ch_flag[n]); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_chf && wdata[n] && !ch_evt[n]) |=> !ch_flag[n]); // R4
    AST_NO_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_clr && !wr_chf && !ch_evt[n]) |=> $stable(ch_flag[n])); // R9
    AST_CAP_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit[n] && ch_is_cap[n] && wr_en && !rd_en && !ch_evt[n]) |=> $stable(ch_flag[n])); // R6
    AST_CMP_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit[n] && !ch_is_cap[n] && rd_en && !wr_en && !ch_evt[n]) |=> $stable(ch_flag[n])); // R7
  end

  assign ovf_clr = (wr_ovf && wdata[7]) || (fast_clr && cnt_hit && (rd_en || wr_en));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= ovf_evt | (ovf_flag & ~ovf_clr);

  always_comb begin
    rdata = 8'h00;
    if (addr == CH_FLAG_ADDR)       rdata = ch_flag;
    else if (addr == OVF_FLAG_ADDR) rdata = {ovf_flag, 7'b0};
  end

  assign ch_irq  = ch_flag & ch_ie;
  assign ovf_irq = ovf_flag & ovf_ie;

  AST_OVF_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr && cnt_hit && (rd_en || wr_en) && !ovf_evt) |=> !ovf_flag); // R8
  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag); // R10
  AST_OVF_RD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cnt_hit && !ovf_evt) |=> $stable(ovf_flag)); // R5
endmodule

// File: tb/sim_tmr_flag_unit.sv
module sim_tmr_flag_unit;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [7:0] a, wd, evt, cap, ie, rdata, ch_irq;
  logic we, re, oe, fc, oie, ovf_irq;
  logic [7:0] m_ch, last_rd;
  logic m_ovf;
  int checks = 0, fails = 0;
  bit done = 0;

  tmr_flag_unit u0 (.clk(clk), .rst_n(rst_n), .addr(a), .wdata(wd), .wr_en(we), .rd_en(re),
    .rdata(rdata), .ch_evt(evt), .ovf_evt(oe), .ch_is_cap(cap), .fast_clr(fc),
    .ch_ie(ie), .ovf_ie(oie), .ch_irq(ch_irq), .ovf_irq(ovf_irq));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    if (a == 8'h8E) return m_ch;
    if (a == 8'h8F) return {m_ovf, 7'b0};
    return 8'h00;
  endfunction

  function automatic logic [7:0] ch_clear();
    logic [7:0] c = (we && a == 8'h8E) ? wd : 8'h00;
    for (int n = 0; n < 8; n++)
      if (fc && (a >> 1) == 8'h48 + 8'(n) && (cap[n] ? re : we)) c[n] = 1'b1;
    return c;
  endfunction

  function automatic logic ovf_clear();
    return (we && a == 8'h8F && wd[7]) || (fc && (a == 8'h84 || a == 8'h85) && (re || we));
  endfunction

  task automatic idle();
    a = 8'h00; wd = 0; we = 0; re = 0; evt = 0; oe = 0;
  endtask

  task automatic step();
    logic [7:0] c;
    logic oc;
    #1;
    last_rd = rdata;
    chk((a == 8'h8E) ? "R2" : (a == 8'h8F) ? "R3" : "R12", {8'h0, rdata}, {8'h0, exp_rd()});
    chk("R11", {7'h0, ovf_irq, ch_irq}, {7'h0, m_ovf & oie, m_ch & ie});
    c = ch_clear(); oc = ovf_clear();
    @(posedge clk);
    m_ch = evt | (m_ch & ~c);
    m_ovf = oe | (m_ovf & ~oc);
    #3;
  endtask

  task automatic rd(logic [7:0] ad);
    idle(); a = ad; re = 1; step(); idle();
  endtask

  task automatic wr(logic [7:0] ad, logic [7:0] d);
    idle(); a = ad; wd = d; we = 1; step(); idle();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle(); cap = 0; fc = 0; ie = 8'hFF; oie = 1; m_ch = 0; m_ovf = 0;
    #25;
    a = 8'h8E; #1;
    chk("R1", {7'h0, ovf_irq, ch_irq}, 16'h0);
    chk("R1", {8'h0, rdata}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    rd(8'h8F); chk("R1", {8'h0, last_rd}, 16'h0);

    evt = 8'h81; step(); idle();
    rd(8'h8E); chk("R2", {8'h0, last_rd}, 16'h81);
    rd(8'h8E); chk("R5", {8'h0, last_rd}, 16'h81);
    wr(8'h8E, 8'h01); rd(8'h8E); chk("R4", {8'h0, last_rd}, 16'h80);
    wr(8'h8E, 8'h00); rd(8'h8E); chk("R4", {8'h0, last_rd}, 16'h80);
    oe = 1; step(); idle();
    rd(8'h8F); chk("R3", {8'h0, last_rd}, 16'h80);

    evt = 8'h04; step(); idle();
    fc = 0; cap = 8'h04;
    rd(8'h94); wr(8'h95, 8'hFF); rd(8'h84); wr(8'h85, 8'h00);
    rd(8'h8E); chk("R9", {8'h0, last_rd}, 16'h84);
    rd(8'h8F); chk("R9", {8'h0, last_rd}, 16'h80);
    fc = 1;
    wr(8'h95, 8'h00); rd(8'h8E); chk("R6", {8'h0, last_rd}, 16'h84);
    rd(8'h95); rd(8'h8E); chk("R6", {8'h0, last_rd}, 16'h80);
    rd(8'h9E); rd(8'h8E); chk("R7", {8'h0, last_rd}, 16'h80);
    wr(8'h9F, 8'h12); rd(8'h8E); chk("R7", {8'h0, last_rd}, 16'h00);
    wr(8'h85, 8'h00); rd(8'h8F); chk("R8", {8'h0, last_rd}, 16'h00);
    oe = 1; step(); idle();
    rd(8'h84); rd(8'h8F); chk("R8", {8'h0, last_rd}, 16'h00);
    fc = 0;
    wr(8'h8F, 8'h7F); oe = 1; step(); idle();
    wr(8'h8F, 8'h7F); rd(8'h8F); chk("R4", {8'h0, last_rd}, 16'h80);
    wr(8'h8F, 8'h80); rd(8'h8F); chk("R4", {8'h0, last_rd}, 16'h00);

    evt = 8'h02; step(); idle();
    a = 8'h8E; we = 1; wd = 8'h02; evt = 8'h02; step(); idle();
    rd(8'h8E); chk("R10", {8'h0, last_rd}, 16'h02);
    a = 8'h8F; we = 1; wd = 8'h80; oe = 1; step(); idle();
    rd(8'h8F); chk("R10", {8'h0, last_rd}, 16'h80);
    fc = 1; cap = 8'h00;
    a = 8'h93; we = 1; evt = 8'h02; step(); idle();
    rd(8'h8E); chk("R10", {8'h0, last_rd}, 16'h02);

    ie = 8'h00; oie = 0; #1; chk("R11", {7'h0, ovf_irq, ch_irq}, 16'h0);
    ie = 8'h02; oie = 1; #1; chk("R11", {7'h0, ovf_irq, ch_irq}, 16'h0102);
    rd(8'h00); chk("R12", {8'h0, last_rd}, 16'h00);
    rd(8'h92); chk("R12", {8'h0, last_rd}, 16'h00);
    rd(8'hFF); chk("R12", {8'h0, last_rd}, 16'h00);

    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(0, 9);
      case (s)
        0: a = 8'h8E;
        1: a = 8'h8F;
        2, 3: a = 8'h84 + 8'($urandom_range(0, 1));
        4, 5, 6, 7: a = 8'h90 + 8'($urandom_range(0, 15));
        default: a = 8'($urandom);
      endcase
      wd = 8'($urandom);
      we = ($urandom_range(0, 1) == 1);
      re = ($urandom_range(0, 1) == 1);
      evt = 8'($urandom & $urandom & $urandom);
      oe = ($urandom_range(0, 5) == 0);
      cap = 8'($urandom);
      fc = ($urandom_range(0, 2) != 0);
      ie = 8'($urandom);
      oie = ($urandom_range(0, 1) == 1);
      step();
    end
    idle(); step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule